// File: doc/BRIEF.md
# LCD Segment Scan and Drive Encoder

This block is the refresh engine on the segment side of a dot-matrix LCD column driver. A 6-bit scan-line counter picks which display line goes to the panel. A frame-sync input loads the counter from a start-line value, which gives hardware vertical scrolling. A line clock moves the counter on by one line. Each time the line changes, a small fetch engine reads one byte per column from the display RAM and pulls the bit for the current line from each byte into a shadow row. The next rising line clock moves the shadow row into the output latch.

Each segment output is a 2-bit drive-level code. The code comes from the latched dot, the alternating phase input (M) and a display-enable flag that is sampled on the line clock. A column-order input picks which end of the RAM row drives the first segment. The analog bias ladder and the host bus are outside this block. The display RAM sits outside as well and is reached through a registered read port.

The fetch engine is a three-state machine. S_IDLE waits for a launch. A launch moves it to S_ISSUE from any state. S_ISSUE issues one column read per cycle and goes to S_DRAIN after the last column. S_DRAIN takes in the final read byte and returns to S_IDLE. A launch is issued one cycle after a falling line-clock edge, and one cycle after frame sync goes low.

Top module: `lcdseg_scan_top`

## Requirements
- R1: While reset is held low, and straight after it is released, `cur_line` is 0, the latched row is all zeros and the display is latched off. With M low, every segment code is 2'b01.
- R2: On every clock where `frame_sync` is high, `start_line` is loaded into the line counter, and `cur_line` shows that value one clock later.
- R3: A falling edge of `line_clk` while `frame_sync` is low adds one to `cur_line`, and 63 wraps to 0. With no such edge and `frame_sync` low, `cur_line` holds its value.
- R4: For line L, column c is read at `ram_addr` = {L[5:3], c[5:0]}, with read data valid one clock after `ram_rd_en`. Bit L[2:0] of that byte is the dot, and bit 0 is the top line of a page. All 64 columns are fetched within 66 clocks of the launch.
- R5: The latched row changes only on a rising edge of `line_clk`. A fetch that runs during the low phase of the line clock leaves the segment outputs unchanged.
- R6: Segment s (0-based, the code on `seg_lvl[2s+1:2s]`) shows column s when `col_fwd` is high, and column 63-s when `col_fwd` is low.
- R7: The codes are 2'b00=V0, 2'b01=V2, 2'b10=V3 and 2'b11=V5. With the display on, a lit dot gives V0 when M is low and V5 when M is high, and a dark dot gives V2 and V3 in the same way. M takes effect without waiting for the line clock, so bit 1 of every code always equals M.
- R8: `disp_on` is captured only on a rising edge of `line_clk`. While the captured flag is off, every segment shows the non-select level whatever the RAM holds: V2 (2'b01) when M is low, V3 (2'b10) when M is high.
- R9: If frame sync is high in the same clock as a falling line-clock edge, the start-line load wins and the counter does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame sync; while high, loads the start line |
| line_clk | input | 1 | Line clock, sampled by clk; rise latches the row, fall steps the line |
| alt_phase | input | 1 | Alternating drive phase (M) |
| col_fwd | input | 1 | Column order: 1 = column s drives segment s |
| disp_on | input | 1 | Display-enable request, captured on a rising line clock |
| start_line | input | 6 | First line shown after frame sync |
| ram_rd_en | output | 1 | Display RAM read strobe |
| ram_addr | output | 9 | Display RAM byte address {page, column} |
| ram_rd_data | input | 8 | RAM read byte, valid one clock after the strobe |
| cur_line | output | 6 | Current scan line |
| seg_lvl | output | 128 | 2-bit drive code per segment, segment 0 in bits 1:0 |

## Verification
The bench goes after the line wrap from 63 to 0 and a start line close to the top, where it must scan 60..63 and then 0. A counter without the wrap, or one that loads from the wrong place, would show the wrong rows. It sets frame sync in the same clock as a line-clock fall. A counter that let the step win would end one line past the start. It samples the outputs late in the low phase, after the next fetch has filled the shadow row. A latch that is not gated by the rising edge would show the next line too early. It turns the display off and on in the middle of a line. A flag that is not synchronised would blank the panel before the rising edge, and a blanked display that drove V2 in both phases would fail once M is high. It runs both column orders on rows that differ in every byte, with a different bit per line, so a reversed column map, a wrong page or a wrong bit select all show up.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;

    // Drive level codes on each segment output
    typedef enum logic [1:0] {
        LV_V0 = 2'b00,
        LV_V2 = 2'b01,
        LV_V3 = 2'b10,
        LV_V5 = 2'b11
    } lvl_e;

    // Fetch engine states
    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_ISSUE = 2'b01,
        S_DRAIN = 2'b10
    } fetch_st_e;

    // Select level only when the display is on and the dot is lit.
    function automatic lvl_e drive_code(input logic on, input logic dot, input logic m);
        if (on && dot)
            return m ? LV_V5 : LV_V0;
        else
            return m ? LV_V3 : LV_V2;
    endfunction

endpackage

// File: rtl/lcdseg_edge.sv
module lcdseg_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic pulse
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sig_q <= 1'b0;
        else
            sig_q <= sig_in;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = sig_in & ~sig_q;
        end else begin : g_fall
            assign pulse = ~sig_in & sig_q;
        end
    endgenerate

endmodule

// File: rtl/lcdseg_line_ctr.sv
module lcdseg_line_ctr #(
    parameter int LINES = 64,
    localparam int LW = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          preset,
    input  logic [LW-1:0] preset_val,
    input  logic          advance,
    output logic [LW-1:0] line
);
    localparam logic [LW-1:0] TOP_LINE = LW'(LINES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            line <= '0;
        else if (preset)
            line <= preset_val;
        else if (advance)
            line <= (line == TOP_LINE) ? '0 : line + LW'(1);
    end

endmodule

// File: rtl/lcdseg_fetch.sv
module lcdseg_fetch
    import lcdseg_pkg::*;
#(
    parameter int COLS   = 64,
    parameter int LINES  = 64,
    parameter int BYTE_W = 8,
    localparam int LW = $clog2(LINES),
    localparam int CW = $clog2(COLS),
    localparam int BW = $clog2(BYTE_W),
    localparam int PW = LW - BW,
    localparam int AW = PW + CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [LW-1:0]     line_in,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [COLS-1:0]   shadow
);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    fetch_st_e       state, state_nxt;
    logic [CW-1:0]   col_cnt;
    logic [LW-1:0]   line_r;
    logic            cap_vld;
    logic [CW-1:0]   cap_col;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nxt;
    end

    // Transitions: launch wins from any state
    always_comb begin
        state_nxt = state;
        if (launch) begin
            state_nxt = S_ISSUE;
        end else begin
            unique case (state)
                S_IDLE:  state_nxt = S_IDLE;
                S_ISSUE: state_nxt = (col_cnt == LAST_COL) ? S_DRAIN : S_ISSUE;
                S_DRAIN: state_nxt = S_IDLE;
                default: state_nxt = S_IDLE;
            endcase
        end
    end

    // Outputs of the state machine
    always_comb begin
        rd_en   = (state == S_ISSUE);
        rd_addr = {line_r[LW-1:BW], col_cnt};
    end

    // Column walker and line snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_cnt <= '0;
            line_r  <= '0;
        end else if (launch) begin
            col_cnt <= '0;
            line_r  <= line_in;
        end else if (state == S_ISSUE) begin
            col_cnt <= col_cnt + CW'(1);
        end
    end

    // Read-data capture, one cycle behind the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld <= 1'b0;
            cap_col <= '0;
            shadow  <= '0;
        end else begin
            cap_vld <= rd_en;
            cap_col <= col_cnt;
            if (cap_vld)
                shadow[cap_col] <= rd_data[line_r[BW-1:0]];
        end
    end

endmodule

// File: rtl/lcdseg_drive.sv
module lcdseg_drive
    import lcdseg_pkg::*;
#(
    parameter int COLS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [COLS-1:0]   row_in,
    input  logic              disp_req,
    input  logic              alt_phase,
    input  logic              col_fwd,
    output logic [COLS-1:0]   row_q,
    output logic              disp_q,
    output logic [2*COLS-1:0] seg_lvl
);
    // Output latch and display flag, both moved on the line-clock rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            disp_q <= 1'b0;
        end else if (load) begin
            row_q  <= row_in;
            disp_q <= disp_req;
        end
    end

    generate
        for (genvar s = 0; s < COLS; s++) begin : g_seg
            logic dot;
            assign dot = col_fwd ? row_q[s] : row_q[COLS-1-s];
            assign seg_lvl[2*s +: 2] = drive_code(disp_q, dot, alt_phase);
        end
    endgenerate

endmodule

// File: rtl/lcdseg_scan_top.sv
module lcdseg_scan_top #(
    parameter int COLS   = 64,
    parameter int LINES  = 64,
    parameter int BYTE_W = 8,
    localparam int LW = $clog2(LINES),
    localparam int CW = $clog2(COLS),
    localparam int BW = $clog2(BYTE_W),
    localparam int AW = LW - BW + CW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              line_clk,
    input  logic              alt_phase,
    input  logic              col_fwd,
    input  logic              disp_on,
    input  logic [LW-1:0]     start_line,
    output logic              ram_rd_en,
    output logic [AW-1:0]     ram_addr,
    input  logic [BYTE_W-1:0] ram_rd_data,
    output logic [LW-1:0]     cur_line,
    output logic [2*COLS-1:0] seg_lvl
);
    logic            cl_rise;
    logic            cl_fall;
    logic            fs_fall;
    logic            launch_q;
    logic [COLS-1:0] shadow_row;
    logic [COLS-1:0] row_lat;
    logic            disp_lat;

    lcdseg_edge #(.RISING(1'b1)) u_cl_rise (
        .clk(clk), .rst_n(rst_n), .sig_in(line_clk), .pulse(cl_rise));

    lcdseg_edge #(.RISING(1'b0)) u_cl_fall (
        .clk(clk), .rst_n(rst_n), .sig_in(line_clk), .pulse(cl_fall));

    lcdseg_edge #(.RISING(1'b0)) u_fs_fall (
        .clk(clk), .rst_n(rst_n), .sig_in(frame_sync), .pulse(fs_fall));

    lcdseg_line_ctr #(.LINES(LINES)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset     (frame_sync),
        .preset_val (start_line),
        .advance    (cl_fall),
        .line       (cur_line)
    );

    // Launch one cycle late so the fetch sees the updated line number
    always_ff @(posedge clk) begin
        if (!rst_n)
            launch_q <= 1'b0;
        else
            launch_q <= cl_fall | fs_fall;
    end

    lcdseg_fetch #(.COLS(COLS), .LINES(LINES), .BYTE_W(BYTE_W)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch_q),
        .line_in (cur_line),
        .rd_en   (ram_rd_en),
        .rd_addr (ram_addr),
        .rd_data (ram_rd_data),
        .shadow  (shadow_row)
    );

    lcdseg_drive #(.COLS(COLS)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cl_rise),
        .row_in    (shadow_row),
        .disp_req  (disp_on),
        .alt_phase (alt_phase),
        .col_fwd   (col_fwd),
        .row_q     (row_lat),
        .disp_q    (disp_lat),
        .seg_lvl   (seg_lvl)
    );

endmodule

// File: rtl/lcdseg_chk.sv
module lcdseg_chk #(
    parameter int COLS  = 64,
    parameter int LINES = 64,
    localparam int LW = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_sync,
    input logic              alt_phase,
    input logic [LW-1:0]     start_line,
    input logic [LW-1:0]     cur_line,
    input logic [2*COLS-1:0] seg_lvl,
    input logic              cl_rise,
    input logic              cl_fall,
    input logic [COLS-1:0]   row_lat,
    input logic              disp_lat
);
    localparam logic [2*COLS-1:0] MSB_MASK = {COLS{2'b10}};
    localparam logic [2*COLS-1:0] NS_LOW   = {COLS{2'b01}};
    localparam logic [2*COLS-1:0] NS_HIGH  = {COLS{2'b10}};

    a_r2_preset: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (cur_line == $past(start_line)));

    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_fall && !frame_sync) |=> (cur_line == ($past(cur_line) + LW'(1))));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cl_fall && !frame_sync) |=> $stable(cur_line));

    a_r5_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cl_rise |=> $stable(row_lat));

    a_r8_disp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cl_rise |=> $stable(disp_lat));

    a_r8_off_nonselect: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_lat |-> (seg_lvl == (alt_phase ? NS_HIGH : NS_LOW)));

    a_r7_phase_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_lvl & MSB_MASK) == (alt_phase ? MSB_MASK : '0));

endmodule

bind lcdseg_scan_top lcdseg_chk #(.COLS(COLS), .LINES(LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_sync (frame_sync),
    .alt_phase  (alt_phase),
    .start_line (start_line),
    .cur_line   (cur_line),
    .seg_lvl    (seg_lvl),
    .cl_rise    (cl_rise),
    .cl_fall    (cl_fall),
    .row_lat    (row_lat),
    .disp_lat   (disp_lat)
);

// File: tb/sim_lcdseg_scan_top.sv
module sim_lcdseg_scan_top;
    localparam int CLK_PERIOD = 10;
    localparam int LOW_WAIT   = 80;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         frame_sync;
    logic         line_clk;
    logic         alt_phase;
    logic         col_fwd;
    logic         disp_on;
    logic [5:0]   start_line;
    logic         ram_rd_en;
    logic [8:0]   ram_addr;
    logic [7:0]   ram_q;
    logic [5:0]   cur_line;
    logic [127:0] seg_lvl;

    logic [7:0]   mem [0:511];
    logic [127:0] last_exp;
    logic         on_exp;
    int           total = 0;
    int           bad   = 0;
    bit           done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) begin
        if (ram_rd_en)
            ram_q <= mem[ram_addr];
    end

    lcdseg_scan_top u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .line_clk(line_clk),
        .alt_phase(alt_phase), .col_fwd(col_fwd), .disp_on(disp_on),
        .start_line(start_line), .ram_rd_en(ram_rd_en), .ram_addr(ram_addr),
        .ram_rd_data(ram_q), .cur_line(cur_line), .seg_lvl(seg_lvl)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_vec(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s seg act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_line(input string tag, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s line act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int a = 0; a < 512; a++)
            mem[a] = 8'((a * 29 + seed * 53) ^ (a >> 3) ^ (seed << a[2:0]));
    endtask

    // Expected code vector from the requirements (R4, R6, R7, R8)
    function automatic logic [127:0] exp_vec(input int ln, input bit fwd, input bit on, input bit m);
        logic [127:0] v;
        for (int s = 0; s < 64; s++) begin
            int  col;
            bit  dot;
            col = fwd ? s : 63 - s;
            dot = mem[(ln / 8) * 64 + col][ln % 8];
            if (on && dot)
                v[2*s +: 2] = m ? 2'b11 : 2'b00;
            else
                v[2*s +: 2] = m ? 2'b10 : 2'b01;
        end
        return v;
    endfunction

    task automatic start_frame(input int s);
        start_line = 6'(s);
        frame_sync = 1'b1;
        tick(3);
        frame_sync = 1'b0;
        tick(1);
        check_line("R2 preset", cur_line, 6'(s));
        tick(LOW_WAIT);
    endtask

    task automatic do_line(input int ln);
        line_clk = 1'b1;
        on_exp   = disp_on;
        tick(3);
        last_exp = exp_vec(ln, col_fwd, on_exp, 1'b0);
        check_vec("R4 R6 R7 R8 row", seg_lvl, last_exp);
        check_line("R3 step", cur_line, 6'(ln));
        alt_phase = 1'b1;
        tick(1);
        check_vec("R7 phase high", seg_lvl, exp_vec(ln, col_fwd, on_exp, 1'b1));
        alt_phase = 1'b0;
        tick(3);
        line_clk = 1'b0;
        tick(LOW_WAIT);
        check_vec("R5 latch hold", seg_lvl, last_exp);
    endtask

    initial begin
        rst_n = 1'b0; frame_sync = 1'b0; line_clk = 1'b0; alt_phase = 1'b0;
        col_fwd = 1'b1; disp_on = 1'b0; start_line = '0; ram_q = '0;
        fill(1);
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        check_line("R1 reset line", cur_line, 6'd0);
        check_vec("R1 reset seg", seg_lvl, {64{2'b01}});

        // Frame 1: forward order, full scan with wrap
        disp_on = 1'b1;
        start_frame(0);
        for (int k = 0; k < 66; k++)
            do_line(k % 64);

        // Frame 2: reversed order, new pattern, display toggled mid-frame
        fill(7);
        col_fwd = 1'b0;
        start_frame(45);
        for (int k = 0; k < 12; k++) begin
            if (k == 4) begin
                disp_on = 1'b0;
                tick(2);
                check_vec("R8 sync off", seg_lvl, last_exp);
            end
            if (k == 7) begin
                disp_on = 1'b1;
                alt_phase = 1'b1;
                tick(2);
                check_vec("R8 off high phase", seg_lvl, {64{2'b10}});
                alt_phase = 1'b0;
            end
            do_line(45 + k);
        end

        // Frame 3: start near the top, wrap 63 -> 0
        fill(3);
        col_fwd = 1'b1;
        start_frame(60);
        for (int k = 0; k < 8; k++)
            do_line((60 + k) % 64);

        // R9: frame sync coincident with a line-clock fall
        line_clk = 1'b1;
        tick(2);
        start_line = 6'd17;
        frame_sync = 1'b1;
        line_clk   = 1'b0;
        tick(2);
        frame_sync = 1'b0;
        tick(1);
        check_line("R9 sync priority", cur_line, 6'd17);
        tick(LOW_WAIT);
        do_line(17);
        do_line(18);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule